// File: doc/BRIEF.md
# Two-Clock FIFO with Selectable Read Behaviour and Level Flags

This block moves data words from a write clock domain to an unrelated read clock domain through a small memory array. The write side pushes a word on each write-clock edge with `wr_en` high, as long as the block is not full. The read side has two behaviours, picked by the static input `fwft_en`. In standard mode, each accepted `rd_en` copies the oldest stored word into the output register. In fall-through mode, the oldest word moves into the output register without any request, and `rd_en` consumes it. Because the output register counts as storage in that mode, the block holds one word more, and every level threshold moves up by one word.

Five status outputs report the fill level. Two of them are dual-purpose pins whose meaning follows the mode. The other three are threshold flags: almost-full, almost-empty and half-full. The almost-full and almost-empty offsets come from inputs that are sampled while master reset is held. If the load input is low during reset, a default offset of 3 applies. Pointers cross between the domains as Gray code through two-flop synchronizers. Master reset clears both sides and returns every flag to its empty state.

Top module: `twin_clock_fifo`

## Requirements
- R1: Words leave the block in the same order they were written, with no loss or duplication. After the last stored word has been read, `rd_data` keeps showing that word.
- R2: In standard mode, `wr_flag_n` is 0 (full) once DEPTH words are stored, and 1 otherwise.
- R3: In fall-through mode, `wr_flag_n` is 0 (ready to accept) while fewer than DEPTH+1 words are held, counting the output register. It is 1 once DEPTH+1 words are held.
- R4: In standard mode, `rd_flag_n` is 0 (empty) when no unread word is stored, and 1 otherwise. A read is accepted only while `rd_flag_n` is 1.
- R5: In fall-through mode, the oldest unread word appears on `rd_data` without a read request, and `rd_flag_n` goes to 0 (valid). Only an accepted read with `rd_en` clears it. The output register holds its word while `rd_en` is low.
- R6: `almost_full_n` is 0 when the level is at least C−m, and 1 otherwise. Here C is DEPTH in standard mode and DEPTH+1 in fall-through mode, and m is the full offset.
- R7: `almost_empty_n` is 0 when the level is at most n in standard mode, or at most n+1 in fall-through mode, and 1 otherwise. Here n is the empty offset.
- R8: `half_full_n` is 0 when the level exceeds DEPTH/2 in standard mode, or DEPTH/2+1 in fall-through mode, and 1 otherwise.
- R9: A write while full and a read while nothing is readable are ignored. Neither one moves a pointer or changes stored data or the output.
- R10: After master reset, the flags show the empty state: `wr_flag_n` reads as not full or ready, `rd_flag_n` reads as empty or not valid, `almost_empty_n` is 0, `almost_full_n` is 1, `half_full_n` is 1, and `rd_data` is 0.
- R11: The offsets m and n are taken from `full_ofs` and `empty_ofs` on clock edges while `mrst_n` is low and `ofs_load` is 1. If `ofs_load` is 0, both offsets default to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous to both domains |
| fwft_en | input | 1 | Static mode select: 0 standard, 1 fall-through |
| ofs_load | input | 1 | During reset: 1 takes offsets from the inputs, 0 uses the default of 3 |
| full_ofs | input | $clog2(DEPTH)+1 | Almost-full offset m |
| empty_ofs | input | $clog2(DEPTH)+1 | Almost-empty offset n |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Output register |
| wr_flag_n | output | 1 | Standard mode: full, low active. Fall-through mode: input ready, low active |
| rd_flag_n | output | 1 | Standard mode: empty, low active. Fall-through mode: output valid, low active |
| almost_full_n | output | 1 | Almost-full flag, low active, write clock |
| almost_empty_n | output | 1 | Almost-empty flag, low active, read clock |
| half_full_n | output | 1 | Half-full flag, low active |

## Verification
The bench builds the block with DEPTH=16 and WIDTH=18. The shallow depth means the full boundary is reached in 16 or 17 writes, so every flag transition can be stepped through one word at a time, in both directions and in both modes. Four resets cover four offset settings: the defaults, 5/2, 0/0 and 1/4. Together they place the almost-full and almost-empty edges at the full and empty boundaries, next to them, and in the middle. Overfilling and overdraining the block at each boundary exercises the ignore rules, and the strict word order of every later read shows that no stored word was disturbed.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  // offset used when no values are supplied during master reset
  localparam int unsigned TCF_DEF_OFS = 3;

  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/tcf_ram.sv
module tcf_ram #(
  parameter int W  = 18,
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [W-1:0] store [ENTRIES];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/tcf_ptr_cross.sv
module tcf_ptr_cross #(
  parameter int W = 6
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_bin,
  output logic [W-1:0] dst_bin
);
  function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [W-1:0] from_gray(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] g_src, g_meta, g_dst;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) g_src <= '0;
    else        g_src <= to_gray(src_bin);
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      g_meta <= '0;
      g_dst  <= '0;
    end else begin
      g_meta <= g_src;
      g_dst  <= g_meta;
    end
  end

  assign dst_bin = from_gray(g_dst);
endmodule

// File: rtl/tcf_wr_side.sv
module tcf_wr_side #(
  parameter int DEPTH = 16,
  parameter int PW    = 6,
  parameter int OW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          ofs_load,
  input  logic [OW-1:0] ofs_in,
  input  logic          wr_en,
  input  logic [PW-1:0] rcnt_s,
  input  logic [PW-1:0] rptr_s,
  output logic [PW-1:0] wptr,
  output logic          push,
  output logic [PW-1:0] level,
  output logic          full_r,
  output logic          af_r,
  output logic          hf_r
);
  localparam int HALF = DEPTH / 2;

  logic [OW-1:0] m_q;
  logic [PW-1:0] wptr_n, lvl_n, occ_n;

  function automatic logic [PW-1:0] cap_of(input logic f);
    return PW'(DEPTH) + {{(PW-1){1'b0}}, f};
  endfunction

  function automatic logic full_at(input logic [PW-1:0] lvl, input logic [PW-1:0] occ,
                                   input logic f);
    return (lvl >= cap_of(f)) || (occ >= PW'(DEPTH));
  endfunction

  function automatic logic [PW-1:0] af_mark(input logic [OW-1:0] m, input logic f);
    logic [PW-1:0] c;
    logic [PW-1:0] mm;
    c  = cap_of(f);
    mm = {{(PW-OW){1'b0}}, m};
    return (mm >= c) ? '0 : c - mm;
  endfunction

  function automatic logic [PW-1:0] hf_mark(input logic f);
    return PW'(HALF) + {{(PW-1){1'b0}}, f};
  endfunction

  // offset captured on write-clock edges while master reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) m_q <= ofs_load ? ofs_in : OW'(tcf_pkg::TCF_DEF_OFS);
  end

  assign push   = wr_en & ~full_r;
  assign wptr_n = wptr + {{(PW-1){1'b0}}, push};
  assign level  = wptr - rcnt_s;
  assign lvl_n  = wptr_n - rcnt_s;
  assign occ_n  = wptr_n - rptr_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      full_r <= 1'b0;
      af_r   <= 1'b0;
      hf_r   <= 1'b0;
    end else begin
      wptr   <= wptr_n;
      full_r <= full_at(lvl_n, occ_n, fwft);
      af_r   <= lvl_n >= af_mark(m_q, fwft);
      hf_r   <= lvl_n > hf_mark(fwft);
    end
  end
endmodule

// File: rtl/tcf_rd_side.sv
module tcf_rd_side #(
  parameter int W  = 18,
  parameter int PW = 6,
  parameter int OW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          ofs_load,
  input  logic [OW-1:0] ofs_in,
  input  logic          rd_en,
  input  logic [PW-1:0] wsync,
  input  logic [W-1:0]  mem_q,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] rcnt,
  output logic          take,
  output logic          load,
  output logic [PW-1:0] level,
  output logic          ov,
  output logic          empty_r,
  output logic          ae_r,
  output logic [W-1:0]  rd_data
);
  logic [OW-1:0] n_q;
  logic [PW-1:0] rptr_n, rcnt_n;
  logic          avail;

  function automatic logic [PW-1:0] ae_mark(input logic [OW-1:0] n, input logic f);
    return {{(PW-OW){1'b0}}, n} + {{(PW-1){1'b0}}, f};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) n_q <= ofs_load ? ofs_in : OW'(tcf_pkg::TCF_DEF_OFS);
  end

  assign avail  = ~empty_r;
  assign take   = fwft ? (rd_en & ov) : (rd_en & avail);
  assign load   = fwft ? (avail & (~ov | take)) : take;
  assign rptr_n = rptr + {{(PW-1){1'b0}}, load};
  assign rcnt_n = rcnt + {{(PW-1){1'b0}}, take};
  assign level  = wsync - rcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr    <= '0;
      rcnt    <= '0;
      ov      <= 1'b0;
      empty_r <= 1'b1;
      ae_r    <= 1'b1;
      rd_data <= '0;
    end else begin
      rptr    <= rptr_n;
      rcnt    <= rcnt_n;
      ov      <= fwft & (load | (ov & ~take));
      empty_r <= (wsync == rptr_n);
      ae_r    <= (wsync - rcnt_n) <= ae_mark(n_q, fwft);
      if (load) rd_data <= mem_q;
    end
  end
endmodule

// File: rtl/twin_clock_fifo.sv
module twin_clock_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 18
) (
  input  logic                       wr_clk,
  input  logic                       rd_clk,
  input  logic                       mrst_n,
  input  logic                       fwft_en,
  input  logic                       ofs_load,
  input  logic [$clog2(DEPTH):0]     full_ofs,
  input  logic [$clog2(DEPTH):0]     empty_ofs,
  input  logic                       wr_en,
  input  logic [WIDTH-1:0]           wr_data,
  input  logic                       rd_en,
  output logic [WIDTH-1:0]           rd_data,
  output logic                       wr_flag_n,
  output logic                       rd_flag_n,
  output logic                       almost_full_n,
  output logic                       almost_empty_n,
  output logic                       half_full_n
);
  import tcf_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 2;
  localparam int OW = AW + 1;

  rd_mode_e      mode;
  logic          fwft;
  logic [PW-1:0] wptr, wr_level, rcnt_s, rptr_s, wsync;
  logic [PW-1:0] rptr, rcnt, rd_level;
  logic          wr_push, full_r, af_r, hf_r;
  logic          rd_take, rd_load, ov, empty_r, ae_r;
  logic [WIDTH-1:0] mem_q;

  assign mode = rd_mode_e'(fwft_en);
  assign fwft = (mode == RD_FWFT);

  tcf_ram #(.W(WIDTH), .AW(AW)) u_ram (
    .wr_clk (wr_clk),
    .we     (wr_push),
    .waddr  (wptr[AW-1:0]),
    .wdata  (wr_data),
    .raddr  (rptr[AW-1:0]),
    .rdata  (mem_q)
  );

  tcf_wr_side #(.DEPTH(DEPTH), .PW(PW), .OW(OW)) u_wr (
    .clk      (wr_clk),
    .rst_n    (mrst_n),
    .fwft     (fwft),
    .ofs_load (ofs_load),
    .ofs_in   (full_ofs),
    .wr_en    (wr_en),
    .rcnt_s   (rcnt_s),
    .rptr_s   (rptr_s),
    .wptr     (wptr),
    .push     (wr_push),
    .level    (wr_level),
    .full_r   (full_r),
    .af_r     (af_r),
    .hf_r     (hf_r)
  );

  tcf_rd_side #(.W(WIDTH), .PW(PW), .OW(OW)) u_rd (
    .clk      (rd_clk),
    .rst_n    (mrst_n),
    .fwft     (fwft),
    .ofs_load (ofs_load),
    .ofs_in   (empty_ofs),
    .rd_en    (rd_en),
    .wsync    (wsync),
    .mem_q    (mem_q),
    .rptr     (rptr),
    .rcnt     (rcnt),
    .take     (rd_take),
    .load     (rd_load),
    .level    (rd_level),
    .ov       (ov),
    .empty_r  (empty_r),
    .ae_r     (ae_r),
    .rd_data  (rd_data)
  );

  // write pointer into the read domain
  tcf_ptr_cross #(.W(PW)) u_x_wptr (
    .src_clk (wr_clk), .dst_clk (rd_clk), .rst_n (mrst_n),
    .src_bin (wptr),   .dst_bin (wsync)
  );

  // memory pop pointer and consumed-word count into the write domain
  tcf_ptr_cross #(.W(PW)) u_x_rptr (
    .src_clk (rd_clk), .dst_clk (wr_clk), .rst_n (mrst_n),
    .src_bin (rptr),   .dst_bin (rptr_s)
  );

  tcf_ptr_cross #(.W(PW)) u_x_rcnt (
    .src_clk (rd_clk), .dst_clk (wr_clk), .rst_n (mrst_n),
    .src_bin (rcnt),   .dst_bin (rcnt_s)
  );

  assign wr_flag_n      = fwft ? full_r : ~full_r;
  assign rd_flag_n      = fwft ? ~ov : ~empty_r;
  assign almost_full_n  = ~af_r;
  assign almost_empty_n = ~ae_r;
  assign half_full_n    = ~hf_r;
endmodule

// File: rtl/tcf_checker.sv
module tcf_checker #(
  parameter int DEPTH = 16,
  parameter int W     = 18,
  parameter int PW    = 6
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          mrst_n,
  input logic          fwft_en,
  input logic          rd_en,
  input logic          wr_push,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] wr_level,
  input logic          full_r,
  input logic          hf_r,
  input logic          rd_take,
  input logic [PW-1:0] rd_level,
  input logic          ov,
  input logic          empty_r,
  input logic          ae_r,
  input logic [W-1:0]  rd_data
);
  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    int'(wr_level) <= DEPTH + int'(fwft_en)); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    rd_take |-> (rd_level != '0)); // R9

  AST_WPTR_HOLD: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    !wr_push |=> $stable(wptr)); // R9

  AST_OUT_HOLD: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    (fwft_en && ov && !rd_en) |=> (ov && $stable(rd_data))); // R5

  AST_FULL_HALF: assert property (@(posedge wr_clk) disable iff (!mrst_n)
    full_r |-> hf_r); // R8

  AST_EMPTY_LOW: assert property (@(posedge rd_clk) disable iff (!mrst_n)
    empty_r |-> ae_r); // R7
endmodule

bind twin_clock_fifo tcf_checker #(.DEPTH(DEPTH), .W(WIDTH), .PW(PW)) u_tcf_checker (
  .wr_clk   (wr_clk),
  .rd_clk   (rd_clk),
  .mrst_n   (mrst_n),
  .fwft_en  (fwft_en),
  .rd_en    (rd_en),
  .wr_push  (wr_push),
  .wptr     (wptr),
  .wr_level (wr_level),
  .full_r   (full_r),
  .hf_r     (hf_r),
  .rd_take  (rd_take),
  .rd_level (rd_level),
  .ov       (ov),
  .empty_r  (empty_r),
  .ae_r     (ae_r),
  .rd_data  (rd_data)
);

// File: tb/twin_clock_fifo_bench.sv
module twin_clock_fifo_bench;
  localparam int DEPTH   = 16;
  localparam int WIDTH   = 18;
  localparam int OW      = $clog2(DEPTH) + 1;
  localparam int WR_HALF = 5;   // write clock period 10
  localparam int RD_HALF = 6;   // read clock period 12
  localparam int WATCHDOG = 1000000;

  logic wr_clk = 1'b0, rd_clk = 1'b0, mrst_n = 1'b0;
  logic fwft_en = 1'b0, ofs_load = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [OW-1:0] full_ofs = '0, empty_ofs = '0;
  logic [WIDTH-1:0] wr_data = '0, rd_data;
  logic wr_flag_n, rd_flag_n, almost_full_n, almost_empty_n, half_full_n;

  int n_chk = 0, n_err = 0;
  logic [WIDTH-1:0] q[$];
  logic [WIDTH-1:0] last_out = '0;
  int f = 0, m = 3, n = 3;

  always #WR_HALF wr_clk = ~wr_clk;
  always #RD_HALF rd_clk = ~rd_clk;

  twin_clock_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_twin_clock_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .fwft_en(fwft_en),
    .ofs_load(ofs_load), .full_ofs(full_ofs), .empty_ofs(empty_ofs),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .wr_flag_n(wr_flag_n), .rd_flag_n(rd_flag_n), .almost_full_n(almost_full_n),
    .almost_empty_n(almost_empty_n), .half_full_n(half_full_n)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  // reference flags restated from the requirements
  task automatic check_all();
    int lvl = q.size();
    int cap = DEPTH + f;
    if (f == 0) begin
      chk("R2", "full flag", {31'd0, wr_flag_n}, (lvl >= cap) ? 0 : 1);
      chk("R4", "empty flag", {31'd0, rd_flag_n}, (lvl == 0) ? 0 : 1);
    end else begin
      chk("R3", "input ready", {31'd0, wr_flag_n}, (lvl >= cap) ? 1 : 0);
      chk("R5", "output valid", {31'd0, rd_flag_n}, (lvl == 0) ? 1 : 0);
    end
    chk("R6", "almost full", {31'd0, almost_full_n}, (lvl >= cap - m) ? 0 : 1);
    chk("R7", "almost empty", {31'd0, almost_empty_n}, (lvl <= n + f) ? 0 : 1);
    chk("R8", "half full", {31'd0, half_full_n}, (lvl > DEPTH / 2 + f) ? 0 : 1);
    if (lvl == cap - m) chk("R11", "af at offset edge", {31'd0, almost_full_n}, 0);
    if (lvl == n + f + 1) chk("R11", "ae just above edge", {31'd0, almost_empty_n}, 1);
    if (f == 1 && lvl > 0) chk("R5", "head on output", 32'(rd_data), 32'(q[0]));
    else                   chk("R1", "held output", 32'(rd_data), 32'(last_out));
  endtask

  task automatic do_write(input logic [WIDTH-1:0] d);
    bit was_full = (q.size() >= DEPTH + f);
    @(negedge wr_clk); wr_en = 1'b1; wr_data = d;
    @(negedge wr_clk); wr_en = 1'b0;
    if (!was_full) q.push_back(d);
    settle();
    check_all();
    if (was_full) chk("R9", "write while full kept level flag", {31'd0, wr_flag_n}, f ? 1 : 0);
  endtask

  task automatic do_read();
    bit was_empty = (q.size() == 0);
    @(negedge rd_clk); rd_en = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0;
    if (!was_empty) last_out = q.pop_front();
    settle();
    check_all();
    if (was_empty) chk("R9", "read while empty kept output", 32'(rd_data), 32'(last_out));
  endtask

  task automatic do_reset(input logic fw, input logic use_ofs, input int mo, input int no);
    mrst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    fwft_en = fw; ofs_load = use_ofs; full_ofs = OW'(mo); empty_ofs = OW'(no);
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
    mrst_n = 1'b1;
    f = fw ? 1 : 0;
    m = use_ofs ? mo : 3;
    n = use_ofs ? no : 3;
    q.delete();
    last_out = '0;
    settle();
    chk("R10", "reset wr flag", {31'd0, wr_flag_n}, fw ? 0 : 1);
    chk("R10", "reset rd flag", {31'd0, rd_flag_n}, fw ? 1 : 0);
    chk("R10", "reset almost empty", {31'd0, almost_empty_n}, 0);
    chk("R10", "reset almost full", {31'd0, almost_full_n}, 1);
    chk("R10", "reset half full", {31'd0, half_full_n}, 1);
    chk("R10", "reset data", 32'(rd_data), 0);
  endtask

  task automatic run_mode(input logic fw, input logic use_ofs, input int mo, input int no,
                          input int seed);
    do_reset(fw, use_ofs, mo, no);
    for (int i = 0; i < DEPTH + 3; i++) do_write(WIDTH'(seed * 4099 + i * 1237 + 5));
    for (int i = 0; i < DEPTH + 3; i++) do_read();
    for (int i = 0; i < 5; i++) do_write(WIDTH'(seed * 77 + i * 31 + 1));
    repeat (2) do_read();
    for (int i = 0; i < 3; i++) do_write(WIDTH'(seed * 91 + i * 513 + 2));
    repeat (7) do_read();
  endtask

  initial begin
    #(WATCHDOG);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    run_mode(1'b0, 1'b0, 0, 0, 1);   // standard, default offsets
    run_mode(1'b1, 1'b1, 5, 2, 2);   // fall-through, loaded offsets
    run_mode(1'b0, 1'b1, 0, 0, 3);   // standard, offsets at the boundaries
    run_mode(1'b1, 1'b1, 1, 4, 4);   // fall-through, offsets near the boundaries
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule